// File: doc/BRIEF.md
# Single-Cycle Integer Subset Processor Core

This block is a 32-bit processor core that completes one instruction on every clock. It reads an instruction word at the address held in its program counter. It decodes the opcode and function fields and reads two source registers from a 32-entry register file. It then computes either an ALU result or an effective address, and in the same cycle it either commits a register write, drives a data memory write, or redirects the program counter. The supported operations are add, sub, addi, lw, sw, beq, bne and j.

Both memories are outside the core and are read combinationally. The instruction word for the current program counter and the load data for the current effective address must be valid within the same cycle. A debug read port gives combinational access to any register, so that surrounding logic or a test harness can inspect the architectural state. Two status outputs are valid for the cycle of the instruction that raises them:
- one marks an unsupported encoding;
- one marks a word access whose address is not a multiple of four.

Top module: `sc_core`

## Requirements
- R1: While reset is high at a rising edge, the program counter becomes 0 and all 32 registers become 0; both are visible on imem_addr and the debug port after that edge.
- R2: Register 0 always reads as 0, and any write aimed at register 0 is discarded.
- R3: With opcode 0, funct 32 writes rs+rt into rd and funct 34 writes rs-rt into rd, both modulo 2^32. The shamt field [10:6] is ignored.
- R4: Opcode 8 (addi) writes rs plus the sign-extended immediate [15:0] into rt.
- R5: Opcode 35 (lw) presents rs plus the sign-extended immediate on dmem_addr. In the same cycle it writes dmem_rdata into rt.
- R6: Opcode 43 (sw) presents the effective address on dmem_addr and the rt value on dmem_wdata, and raises dmem_we for that cycle only. It writes no register.
- R7: For lw or sw with an effective address whose bits [1:0] are nonzero, mem_misalign is high for that cycle, dmem_we stays low and no register changes. mem_misalign is low for every other instruction.
- R8: Opcodes 4 (beq) and 5 (bne) compare rs with rt. When the branch is taken, the program counter becomes PC+4 plus the sign-extended offset shifted left by 2. When it is not taken, the program counter becomes PC+4.
- R9: Opcode 2 (j) sets the program counter to bits [31:28] of PC+4, then the 26-bit target [25:0], then two zero bits.
- R10: Every other opcode, and opcode 0 with a funct other than 32 or 34, raises illegal for that cycle. Such an instruction writes no register and no memory, and the program counter advances by 4.
- R11: Every instruction that is not a taken branch or a jump advances the program counter by 4, modulo 2^32.
- R12: dbg_data combinationally returns the current value of the register selected by dbg_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Program counter, byte address of the instruction |
| imem_rdata | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Effective byte address for load and store |
| dmem_wdata | output | 32 | Store data (rt value) |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_rdata | input | 32 | Load data for dmem_addr |
| dbg_sel | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Value of the selected register |
| illegal | output | 1 | Current instruction is unsupported |
| mem_misalign | output | 1 | Current load or store address is not word aligned |

## Verification
The assertions assume that imem_rdata and dmem_rdata are stable and known for the whole cycle in which they are consumed. They also assume that reset is held for at least one rising edge before the first instruction counts. The bench changes both memory inputs only at falling edges and holds each value through the following rising edge, so every value is settled when the core registers it. Reset is released well away from any edge. Because the bench supplies every instruction directly, the program counter may wander into any address, including one that wraps past the top of the address space, without any memory model having to follow it.

// File: rtl/mcore_pkg.sv
`timescale 1ns/1ps
package mcore_pkg;
    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RIDX   = $clog2(NREG);
    localparam int IMMW   = 16;
    localparam int TGTW   = 26;
    localparam int OPW    = 6;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [RIDX-1:0] ridx_t;

    localparam logic [OPW-1:0] OPC_REG   = 6'd0;
    localparam logic [OPW-1:0] OPC_JUMP  = 6'd2;
    localparam logic [OPW-1:0] OPC_BEQ   = 6'd4;
    localparam logic [OPW-1:0] OPC_BNE   = 6'd5;
    localparam logic [OPW-1:0] OPC_ADDI  = 6'd8;
    localparam logic [OPW-1:0] OPC_LOAD  = 6'd35;
    localparam logic [OPW-1:0] OPC_STORE = 6'd43;
    localparam logic [5:0]     FN_ADD    = 6'd32;
    localparam logic [5:0]     FN_SUB    = 6'd34;

    typedef enum logic [0:0] {ALU_ADD, ALU_SUB} alu_op_e;
    typedef enum logic [1:0] {PC_SEQ, PC_BEQ, PC_BNE, PC_JMP} pc_sel_e;

    typedef struct packed {
        logic [OPW-1:0]  op;
        ridx_t           rs;
        ridx_t           rt;
        ridx_t           rd;
        logic [5:0]      funct;
        logic [IMMW-1:0] imm;
        logic [TGTW-1:0] target;
    } fields_t;

    typedef struct packed {
        logic    legal;
        logic    reg_we;
        ridx_t   wsel;
        logic    use_imm;
        alu_op_e alu_op;
        logic    mem_rd;
        logic    mem_wr;
        pc_sel_e pc_sel;
    } ctrl_t;

    function automatic fields_t split_fields(input word_t w);
        fields_t f;
        f.op     = w[31:26];
        f.rs     = w[25:21];
        f.rt     = w[20:16];
        f.rd     = w[15:11];
        f.funct  = w[5:0];
        f.imm    = w[15:0];
        f.target = w[25:0];
        return f;
    endfunction

    function automatic word_t sext_imm(input logic [IMMW-1:0] v);
        return {{(XLEN-IMMW){v[IMMW-1]}}, v};
    endfunction
endpackage

// File: rtl/mcore_decode.sv
`timescale 1ns/1ps
module mcore_decode
    import mcore_pkg::*;
(
    input  word_t           instr,
    output ridx_t           rs,
    output ridx_t           rt,
    output logic [IMMW-1:0] imm16,
    output logic [TGTW-1:0] target,
    output word_t           imm_ext,
    output ctrl_t           ctl
);
    fields_t fld;

    always_comb begin
        fld     = split_fields(instr);
        rs      = fld.rs;
        rt      = fld.rt;
        imm16   = fld.imm;
        target  = fld.target;
        imm_ext = sext_imm(fld.imm);

        ctl        = '0;
        ctl.wsel   = fld.rt;
        ctl.alu_op = ALU_ADD;
        ctl.pc_sel = PC_SEQ;

        case (fld.op)
            OPC_REG: begin
                if (fld.funct == FN_ADD || fld.funct == FN_SUB) begin
                    ctl.legal  = 1'b1;
                    ctl.reg_we = 1'b1;
                    ctl.wsel   = fld.rd;
                    ctl.alu_op = (fld.funct == FN_SUB) ? ALU_SUB : ALU_ADD;
                end
            end
            OPC_ADDI: begin
                ctl.legal   = 1'b1;
                ctl.reg_we  = 1'b1;
                ctl.use_imm = 1'b1;
            end
            OPC_LOAD: begin
                ctl.legal   = 1'b1;
                ctl.reg_we  = 1'b1;
                ctl.use_imm = 1'b1;
                ctl.mem_rd  = 1'b1;
            end
            OPC_STORE: begin
                ctl.legal   = 1'b1;
                ctl.use_imm = 1'b1;
                ctl.mem_wr  = 1'b1;
            end
            OPC_BEQ: begin
                ctl.legal  = 1'b1;
                ctl.alu_op = ALU_SUB;
                ctl.pc_sel = PC_BEQ;
            end
            OPC_BNE: begin
                ctl.legal  = 1'b1;
                ctl.alu_op = ALU_SUB;
                ctl.pc_sel = PC_BNE;
            end
            OPC_JUMP: begin
                ctl.legal  = 1'b1;
                ctl.pc_sel = PC_JMP;
            end
            default: ;
        endcase
    end

    // R10: an unsupported encoding may not request any side effect
    always_comb begin
        a_r10_no_side_effect: assert (ctl.legal || !(ctl.reg_we || ctl.mem_wr || ctl.mem_rd));
    end
endmodule

// File: rtl/mcore_regfile.sv
`timescale 1ns/1ps
module mcore_regfile #(
    parameter int NR = 32,
    parameter int W  = 32,
    localparam int IW = $clog2(NR)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] ra_sel,
    input  logic [IW-1:0] rb_sel,
    input  logic [IW-1:0] rc_sel,
    input  logic          we,
    input  logic [IW-1:0] wsel,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  ra,
    output logic [W-1:0]  rb,
    output logic [W-1:0]  rc
);
    logic [W-1:0] regs_q [NR];

    assign regs_q[0] = '0;

    for (genvar g = 1; g < NR; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[g] <= '0;
            else if (we && wsel == IW'(g))
                regs_q[g] <= wdata;
        end
    end

    assign ra = regs_q[ra_sel];
    assign rb = regs_q[rb_sel];
    assign rc = regs_q[rc_sel];

    // R12: a write to a nonzero register is readable on the next cycle
    a_r12_write_lands: assert property (@(posedge clk) disable iff (rst)
        (we && wsel != '0 && wsel == rc_sel) |=> (rc == $past(wdata) || rc_sel != $past(rc_sel)));
    // R2: register 0 stays zero whatever is written to it
    a_r2_zero_holds: assert property (@(posedge clk) disable iff (rst)
        (rc_sel == '0) |-> (rc == '0));
endmodule

// File: rtl/mcore_alu.sv
`timescale 1ns/1ps
module mcore_alu
    import mcore_pkg::*;
(
    input  word_t   a,
    input  word_t   b,
    input  alu_op_e op,
    output word_t   y,
    output logic    zero
);
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            default: y = a + b;
        endcase
        zero = (y == '0);
    end
endmodule

// File: rtl/mcore_nextpc.sv
`timescale 1ns/1ps
module mcore_nextpc
    import mcore_pkg::*;
(
    input  word_t           pc,
    input  pc_sel_e         sel,
    input  logic            equal,
    input  logic [IMMW-1:0] off16,
    input  logic [TGTW-1:0] target,
    output word_t           npc,
    output logic            redirect
);
    word_t pc4;
    word_t br_tgt;
    word_t jmp_tgt;
    word_t off_ext;

    always_comb begin
        pc4     = pc + word_t'(4);
        off_ext = sext_imm(off16);
        br_tgt  = pc4 + {off_ext[XLEN-3:0], 2'b00};
        jmp_tgt = {pc4[XLEN-1:XLEN-4], target, 2'b00};
        case (sel)
            PC_BEQ:  redirect = equal;
            PC_BNE:  redirect = !equal;
            PC_JMP:  redirect = 1'b1;
            default: redirect = 1'b0;
        endcase
        if (sel == PC_JMP)
            npc = jmp_tgt;
        else if (redirect)
            npc = br_tgt;
        else
            npc = pc4;
    end
endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
    import mcore_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata,
    input  logic [4:0]  dbg_sel,
    output logic [31:0] dbg_data,
    output logic        illegal,
    output logic        mem_misalign
);
    word_t           pc_q;
    word_t           pc_next;
    ridx_t           rs_sel;
    ridx_t           rt_sel;
    logic [IMMW-1:0] imm16;
    logic [TGTW-1:0] target;
    word_t           imm_ext;
    ctrl_t           ctl;
    word_t           rs_val;
    word_t           rt_val;
    word_t           alu_b;
    word_t           alu_y;
    logic            alu_zero;
    logic            redirect;
    logic            rf_we;
    word_t           rf_wdata;

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else
            pc_q <= pc_next;
    end

    mcore_decode u_dec (
        .instr   (imem_rdata),
        .rs      (rs_sel),
        .rt      (rt_sel),
        .imm16   (imm16),
        .target  (target),
        .imm_ext (imm_ext),
        .ctl     (ctl)
    );

    mcore_regfile #(.NR(NREG), .W(XLEN)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .ra_sel (rs_sel),
        .rb_sel (rt_sel),
        .rc_sel (dbg_sel),
        .we     (rf_we),
        .wsel   (ctl.wsel),
        .wdata  (rf_wdata),
        .ra     (rs_val),
        .rb     (rt_val),
        .rc     (dbg_data)
    );

    assign alu_b = ctl.use_imm ? imm_ext : rt_val;

    mcore_alu u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    mcore_nextpc u_npc (
        .pc       (pc_q),
        .sel      (ctl.pc_sel),
        .equal    (alu_zero),
        .off16    (imm16),
        .target   (target),
        .npc      (pc_next),
        .redirect (redirect)
    );

    always_comb begin
        mem_misalign = (ctl.mem_rd || ctl.mem_wr) && (alu_y[1:0] != 2'b00);
        dmem_we      = ctl.mem_wr && !mem_misalign;
        rf_we        = ctl.reg_we && !(ctl.mem_rd && mem_misalign);
        rf_wdata     = ctl.mem_rd ? dmem_rdata : alu_y;
        illegal      = !ctl.legal;
    end

    assign imem_addr  = pc_q;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;

    // R7: a misaligned access never reaches memory
    a_r7_no_misaligned_store: assert property (@(posedge clk) disable iff (rst)
        mem_misalign |-> !dmem_we);
    // R10: an unsupported instruction falls through to the next word
    a_r10_illegal_falls_through: assert property (@(posedge clk) disable iff (rst)
        illegal |=> (imem_addr == $past(imem_addr) + 32'd4));
    // R10: no memory activity from an unsupported instruction
    a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!dmem_we && !mem_misalign));
    // R11: without a redirect the counter moves by one word
    a_r11_sequential: assert property (@(posedge clk) disable iff (rst)
        !redirect |=> (imem_addr == $past(imem_addr) + 32'd4));
    // R8: the fetch address stays word aligned
    a_r8_pc_aligned: assert property (@(posedge clk) disable iff (rst)
        imem_addr[1:0] == 2'b00);
endmodule

// File: tb/sc_core_bench.sv
`timescale 1ns/1ps
module sc_core_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr;
    logic [31:0] imem_rdata = 32'h0000_0020;
    logic [31:0] dmem_addr;
    logic [31:0] dmem_wdata;
    logic        dmem_we;
    logic [31:0] dmem_rdata = '0;
    logic [4:0]  dbg_sel = '0;
    logic [31:0] dbg_data;
    logic        illegal;
    logic        mem_misalign;

    int          n_checks = 0;
    int          n_fails  = 0;
    bit          done     = 1'b0;
    logic [31:0] mreg [32];
    logic [31:0] mpc;
    string       pc_tag;

    always #4 clk = ~clk;

    sc_core u_sc_core (
        .clk          (clk),
        .rst          (rst),
        .imem_addr    (imem_addr),
        .imem_rdata   (imem_rdata),
        .dmem_addr    (dmem_addr),
        .dmem_wdata   (dmem_wdata),
        .dmem_we      (dmem_we),
        .dmem_rdata   (dmem_rdata),
        .dbg_sel      (dbg_sel),
        .dbg_data     (dbg_data),
        .illegal      (illegal),
        .mem_misalign (mem_misalign)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s at pc %h: actual %h expected %h", tag, mpc, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input int sh, input int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
    endfunction

    function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] enc_j(input int tgt);
        return {6'd2, 26'(tgt)};
    endfunction

    function automatic bit op_known(input int op);
        return op == 0 || op == 2 || op == 4 || op == 5 || op == 8 || op == 35 || op == 43;
    endfunction

    task automatic dump(input string tag);
        for (int i = 0; i < 32; i++) begin
            dbg_sel = 5'(i);
            #0.05;
            check(tag, dbg_data, mreg[i]);
        end
    endtask

    // Apply one instruction and check its cycle against the arithmetic model
    task automatic step(input logic [31:0] ins, input logic [31:0] rdv);
        logic [5:0]  op;
        logic [4:0]  rs, rt, rd, wsel;
        logic [5:0]  fn;
        logic [31:0] se, a, b, ea, npc, wval;
        logic        e_mis, e_we, e_ill, wen, memop;
        string       tg;
        op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; fn = ins[5:0];
        se = {{16{ins[15]}}, ins[15:0]};
        a = mreg[rs]; b = mreg[rt]; ea = a + se;
        npc = mpc + 32'd4;
        e_mis = 0; e_we = 0; e_ill = 0; wen = 0; memop = 0; wsel = rt; wval = '0;
        tg = "R11";
        case (op)
            6'd0: begin
                tg = "R3";
                if (fn == 6'd32) begin wen = 1; wsel = rd; wval = a + b; end
                else if (fn == 6'd34) begin wen = 1; wsel = rd; wval = a - b; end
                else begin e_ill = 1; tg = "R10"; end
            end
            6'd8:  begin tg = "R4"; wen = 1; wval = a + se; end
            6'd35: begin
                memop = 1; tg = "R5";
                if (ea[1:0] != 2'b00) begin e_mis = 1; tg = "R7"; end
                else begin wen = 1; wval = rdv; end
            end
            6'd43: begin
                memop = 1; tg = "R6";
                if (ea[1:0] != 2'b00) begin e_mis = 1; tg = "R7"; end
                else e_we = 1;
            end
            6'd4:  begin tg = "R8"; if (a == b) npc = mpc + 32'd4 + (se << 2); end
            6'd5:  begin tg = "R8"; if (a != b) npc = mpc + 32'd4 + (se << 2); end
            6'd2:  begin tg = "R9"; npc = {npc[31:28], ins[25:0], 2'b00}; end
            default: begin e_ill = 1; tg = "R10"; end
        endcase

        @(negedge clk);
        imem_rdata = ins;
        dmem_rdata = rdv;
        #1;
        check(pc_tag, imem_addr, mpc);
        check("R10", 32'(illegal), 32'(e_ill));
        check("R7", 32'(mem_misalign), 32'(e_mis));
        check(e_mis ? "R7" : "R6", 32'(dmem_we), 32'(e_we));
        if (memop) check(tg, dmem_addr, ea);
        if (e_we) check("R6", dmem_wdata, b);

        @(posedge clk);
        #0.5;
        if (wen && wsel != 5'd0) mreg[wsel] = wval;
        pc_tag = (op == 6'd4 || op == 6'd5 || op == 6'd2) ? tg : (e_ill ? "R10" : "R11");
        mpc = npc;
        dbg_sel = rt;
        #0.1;
        check((rt == 5'd0) ? "R2" : tg, dbg_data, mreg[rt]);
        dbg_sel = rd;
        #0.1;
        check((rd == 5'd0) ? "R2" : tg, dbg_data, mreg[rd]);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [15:0] edge_imm [5];
        edge_imm = '{16'h7FFF, 16'h8000, 16'hFFFF, 16'h0000, 16'h0001};
        for (int i = 0; i < 32; i++) mreg[i] = '0;
        mpc = '0;
        pc_tag = "R1";

        // R1: reset state
        repeat (3) @(posedge clk);
        #0.5;
        check("R1", imem_addr, 32'h0);
        dump("R1");
        rst = 1'b0;

        // R4: fill registers from r0 with signed immediates
        for (int k = 1; k < 32; k++) step(enc_i(8, 0, k, k * 1237 - 20000), '0);
        // R5: aligned loads with wide data patterns
        for (int k = 0; k < 32; k++) step(enc_i(35, 0, k, k * 4), (32'(k) * 32'h9E37_79B9) ^ 32'h8000_0001);
        // R3: add and sub over a spread of register triples, shamt varied
        for (int i = 0; i < 32; i++) begin
            step(enc_r(i, (i * 7 + 3) % 32, (i * 13 + 1) % 32, i, 32), '0);
            step(enc_r((i * 7 + 3) % 32, i, (i * 13 + 6) % 32, 0, 34), '0);
        end
        // R4: immediate edge values from nonzero bases
        for (int k = 0; k < 32; k++) step(enc_i(8, k, (k * 3 + 2) % 32, int'(edge_imm[k % 5])), '0);
        // R2: writes aimed at register 0
        step(enc_i(8, 1, 0, 5), '0);
        step(enc_i(35, 0, 0, 0), 32'hFFFF_FFFF);
        step(enc_r(1, 2, 0, 0, 32), '0);
        dump("R2");
        // R6: stores from r0 (negative offsets) and from a register base
        step(enc_i(8, 0, 30, 16'h0100), '0);
        for (int k = 0; k < 32; k++) step(enc_i(43, (k % 2 == 1) ? 30 : 0, k, -4 * k), '0);
        // R7: misaligned loads and stores
        for (int low = 1; low < 4; low++) begin
            step(enc_i(35, 0, 20 + low, 16 + low), 32'hDEAD_BEEF);
            step(enc_i(43, 0, 20 + low, 16 + low), '0);
        end
        step(enc_i(8, 0, 29, 1), '0);
        step(enc_i(35, 29, 28, 3), 32'hCAFE_F00D);
        step(enc_i(43, 29, 28, 7), '0);
        step(enc_i(35, 29, 27, 0), 32'h1234_5678);
        step(enc_i(43, 29, 27, 2), '0);
        // R8: branches, equal and unequal pairs, signed offsets
        step(enc_r(0, 11, 10, 0, 32), '0);
        step(enc_i(4, 10, 11, 3), '0);
        step(enc_i(5, 10, 11, 3), '0);
        for (int k = 0; k < 16; k++) begin
            step(enc_i(4, k, (k % 3 == 0) ? k : k + 1, k - 8), '0);
            step(enc_i(5, k, (k % 3 == 0) ? k : k + 1, 8 - k), '0);
        end
        // R9: jumps to spread targets
        for (int k = 0; k < 8; k++) step(enc_j(k * 32'h0123_457 + 1), '0);
        // R9 and R11: upper bits taken from PC+4, counter wrap
        step(enc_j(0), '0);
        step(enc_i(4, 0, 0, -4), '0);
        step(enc_r(0, 0, 0, 0, 32), '0);
        step(enc_r(0, 0, 0, 0, 32), '0);
        step(enc_r(0, 0, 0, 0, 32), '0);
        step(enc_i(4, 0, 0, -4), '0);
        step(enc_r(0, 0, 0, 0, 32), '0);
        step(enc_j(32'h123), '0);
        // R10: every unsupported opcode and every unsupported funct
        for (int op = 0; op < 64; op++)
            if (!op_known(op)) step(enc_i(op, 7, 9, op * 1031), 32'h5555_AAAA);
        for (int fn = 0; fn < 64; fn++)
            if (fn != 32 && fn != 34) step(enc_r(3, 4, 11, fn % 32, fn), 32'h5555_AAAA);
        // R12: full debug read of the final state
        dump("R12");
        @(negedge clk);
        #1;
        check(pc_tag, imem_addr, mpc);
        done = 1'b1;
        finish_run();
    end
endmodule